// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a program offset into a linear address through a small table of segment descriptors and a bank of six segment registers. Every request carries an access kind, and from that kind the block picks a default segment register. An optional override field can name a different register instead. The chosen register holds an index into the descriptor table. The indexed descriptor supplies a base, a limit and two attribute fields: a privilege bit and an operand-size code.

In legacy mode the offset is checked against the limit. A legal offset yields base plus offset. An illegal offset raises a fault and the address output is forced to zero. In 64-bit mode there is no limit check and every base reads as zero. The one exception is the FS or GS register when an explicit override names it; that base is still added. Results are registered and appear one cycle after the request together with a valid flag. Software fills the descriptor table and the segment registers through one shared write port.

Top module: `seg_xlate_unit`

## Requirements
- R1: In legacy mode (mode64=0), a request whose offset is strictly below the selected descriptor's limit returns linear address = base + offset, with no fault. With descriptor 1 at base 0x50000 and limit 0x6F000, offset 0x23456 gives 0x73456.
- R2: In legacy mode, an offset greater than or equal to the limit sets rsp_fault and drives rsp_addr to zero. An offset equal to the limit faults.
- R3: Without an override, the access kind picks the register: kind 0 (instruction fetch) uses CS, kind 1 (stack) uses SS, kind 2 (data) uses DS, kind 3 (string destination) uses ES. FS and GS are never picked by default.
- R4: With req_ovr_en=1, the override code replaces the default. Codes 0..5 name CS, SS, DS, ES, FS and GS in that order. Codes 6 and 7 are ignored, and the default register is used.
- R5: In 64-bit mode (mode64=1) no fault is raised, and the address is the offset alone. The exception is an override naming FS (code 4) or GS (code 5): that register's descriptor base is added.
- R6: rsp_priv and rsp_size always carry the privilege bit and the size code (0=16-bit, 1=32-bit, 2=64-bit) of the descriptor that was looked up, in either mode and on a fault.
- R7: The response appears on the clock edge after the request. rsp_valid is high exactly in the cycle after a cycle with req_valid high.
- R8: After reset, every descriptor and every segment register is zero and rsp_valid is low. A legacy request made before any write therefore faults, because the limit is zero.
- R9: Write port encoding. With wr_sreg=0, wr_idx selects a descriptor and wr_field selects what is written: 0 = base, 1 = limit, 2 = attributes (wr_data[1:0] is the size code, wr_data[2] is the privilege bit), 3 = nothing. With wr_sreg=1, wr_idx 0..5 selects a segment register in the order of R4, and that register loads wr_data[2:0]. wr_idx 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sreg | input | 1 | 1 = write a segment register, 0 = write a descriptor |
| wr_idx | input | 3 | Descriptor index or segment register code |
| wr_field | input | 2 | Descriptor field select |
| wr_data | input | 64 | Write data |
| mode64 | input | 1 | 1 = 64-bit behaviour, 0 = legacy |
| req_valid | input | 1 | Translation request valid |
| req_kind | input | 2 | Access kind |
| req_ovr_en | input | 1 | Override present |
| req_ovr_seg | input | 3 | Override register code |
| req_offset | input | 64 | Program offset |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 64 | Linear address (zero on fault) |
| rsp_fault | output | 1 | Limit violation |
| rsp_priv | output | 1 | Descriptor privilege bit |
| rsp_size | output | 2 | Descriptor operand-size code |

## Verification
The bench probes offsets exactly at the limit and one below it. A design that compares with "greater than" instead of "greater or equal" passes the first offset and misses the fault. The bench checks that each access kind reaches its own register, and that FS and GS are reached only through an override. A mixed-up default map shows up as a wrong base or wrong attributes. Invalid override codes must fall back to the default register. In 64-bit mode the bench checks that overrides of ordinary registers still drop the base while FS and GS overrides keep it. A design that adds every base, or none, returns a wrong address there.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int ADDR_W = 64;
    localparam int NUM_SREG = 6;
    localparam int SREG_W = 3;

    typedef enum logic [1:0] {
        KIND_FETCH  = 2'd0,
        KIND_STACK  = 2'd1,
        KIND_DATA   = 2'd2,
        KIND_STRDST = 2'd3
    } access_kind_e;

    typedef enum logic [SREG_W-1:0] {
        SR_CS = 3'd0,
        SR_SS = 3'd1,
        SR_DS = 3'd2,
        SR_ES = 3'd3,
        SR_FS = 3'd4,
        SR_GS = 3'd5
    } sreg_e;

    typedef enum logic [1:0] {
        FLD_BASE  = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_ATTR  = 2'd2
    } field_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              fault;
        logic              priv;
        logic [1:0]        size;
    } xlate_rsp_t;
endpackage

// File: rtl/seg_route.sv
module seg_route
    import seg_xlate_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic              ovr_en,
    input  logic [SREG_W-1:0] ovr_seg,
    output logic [SREG_W-1:0] sel_reg,
    output logic              wide_base_ok
);
    logic [SREG_W-1:0] dflt_reg;
    logic              ovr_legal;

    always_comb begin
        unique case (access_kind_e'(kind))
            KIND_FETCH:  dflt_reg = SR_CS;
            KIND_STACK:  dflt_reg = SR_SS;
            KIND_DATA:   dflt_reg = SR_DS;
            default:     dflt_reg = SR_ES;
        endcase
        ovr_legal    = ovr_en && (ovr_seg < SREG_W'(NUM_SREG));
        sel_reg      = ovr_legal ? ovr_seg : dflt_reg;
        wide_base_ok = ovr_legal && (ovr_seg == SR_FS || ovr_seg == SR_GS);
    end
endmodule

// File: rtl/seg_sreg_bank.sv
module seg_sreg_bank
    import seg_xlate_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SREG_W-1:0] wr_reg,
    input  logic [IDX_W-1:0]  wr_val,
    input  logic [SREG_W-1:0] rd_reg,
    output logic [IDX_W-1:0]  rd_idx
);
    logic [IDX_W-1:0] sreg_q [NUM_SREG];

    for (genvar g = 0; g < NUM_SREG; g++) begin : g_sreg
        logic [IDX_W-1:0] sreg_d;
        always_comb begin
            sreg_d = sreg_q[g];
            if (wr_en && wr_reg == SREG_W'(g)) sreg_d = wr_val;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) sreg_q[g] <= '0;
            else        sreg_q[g] <= sreg_d;
        end
    end

    always_comb begin
        rd_idx = '0;
        for (int i = 0; i < NUM_SREG; i++)
            if (rd_reg == SREG_W'(i)) rd_idx = sreg_q[i];
    end
endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_limit,
    output logic [2:0]        rd_attr
);
    logic [ADDR_W-1:0] base_q  [ENTRIES];
    logic [ADDR_W-1:0] limit_q [ENTRIES];
    logic [2:0]        attr_q  [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [ADDR_W-1:0] base_d, limit_d;
        logic [2:0]        attr_d;
        logic              hit;
        always_comb begin
            hit     = wr_en && (wr_idx == IDX_W'(g));
            base_d  = base_q[g];
            limit_d = limit_q[g];
            attr_d  = attr_q[g];
            if (hit && wr_field == FLD_BASE)  base_d  = wr_data;
            if (hit && wr_field == FLD_LIMIT) limit_d = wr_data;
            if (hit && wr_field == FLD_ATTR)  attr_d  = wr_data[2:0];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                attr_q[g]  <= '0;
            end else begin
                base_q[g]  <= base_d;
                limit_q[g] <= limit_d;
                attr_q[g]  <= attr_d;
            end
        end
    end

    assign rd_base  = base_q[rd_idx];
    assign rd_limit = limit_q[rd_idx];
    assign rd_attr  = attr_q[rd_idx];
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sreg,
    input  logic [2:0]        wr_idx,
    input  logic [1:0]        wr_field,
    input  logic [63:0]       wr_data,
    input  logic              mode64,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_ovr_en,
    input  logic [2:0]        req_ovr_seg,
    input  logic [63:0]       req_offset,
    output logic              rsp_valid,
    output logic [63:0]       rsp_addr,
    output logic              rsp_fault,
    output logic              rsp_priv,
    output logic [1:0]        rsp_size
);
    logic [SREG_W-1:0] sel_reg;
    logic              wide_base_ok;
    logic [IDX_W-1:0]  desc_idx;
    logic [ADDR_W-1:0] desc_base, desc_limit;
    logic [2:0]        desc_attr;
    xlate_rsp_t        rsp_d, rsp_q;

    seg_route u_route (
        .kind         (req_kind),
        .ovr_en       (req_ovr_en),
        .ovr_seg      (req_ovr_seg),
        .sel_reg      (sel_reg),
        .wide_base_ok (wide_base_ok)
    );

    seg_sreg_bank #(.IDX_W(IDX_W)) u_sregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en && wr_sreg),
        .wr_reg (wr_idx),
        .wr_val (wr_data[IDX_W-1:0]),
        .rd_reg (sel_reg),
        .rd_idx (desc_idx)
    );

    seg_desc_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && !wr_sreg),
        .wr_idx   (wr_idx[IDX_W-1:0]),
        .wr_field (wr_field),
        .wr_data  (wr_data),
        .rd_idx   (desc_idx),
        .rd_base  (desc_base),
        .rd_limit (desc_limit),
        .rd_attr  (desc_attr)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.priv = desc_attr[2];
            rsp_d.size = desc_attr[1:0];
            if (mode64) begin
                rsp_d.fault = 1'b0;
                rsp_d.addr  = req_offset + (wide_base_ok ? desc_base : '0);
            end else begin
                rsp_d.fault = (req_offset >= desc_limit);
                rsp_d.addr  = rsp_d.fault ? '0 : desc_base + req_offset;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_fault = rsp_q.fault;
    assign rsp_priv  = rsp_q.priv;
    assign rsp_size  = rsp_q.size;

    assert_rsp_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_no_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_fault_zero_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_addr == '0);
    assert_limit_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode64 && req_offset >= desc_limit) |=> rsp_fault);
    assert_wide_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode64) |=> !rsp_fault);
    assert_no_fs_gs_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ovr_en) |-> sel_reg < SR_FS);
endmodule

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sreg = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_field = '0;
    logic [63:0] wr_data = '0;
    logic        mode64 = 1'b0, req_valid = 1'b0, req_ovr_en = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_ovr_seg = '0;
    logic [63:0] req_offset = '0;
    logic        rsp_valid, rsp_fault, rsp_priv;
    logic [63:0] rsp_addr;
    logic [1:0]  rsp_size;
    int          n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    seg_xlate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sreg(wr_sreg), .wr_idx(wr_idx),
        .wr_field(wr_field), .wr_data(wr_data), .mode64(mode64), .req_valid(req_valid),
        .req_kind(req_kind), .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg),
        .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_priv(rsp_priv), .rsp_size(rsp_size)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic        ovr_en;
        logic [2:0]  ovr;
        logic        m64;
        logic [63:0] off;
        logic [63:0] addr;
        logic        fault;
        logic        priv;
        logic [1:0]  size;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 1'b0, 3'd0, 1'b0, 64'h23456,     64'h73456,     1'b0, 1'b0, 2'd1},
        '{2'd0, 1'b0, 3'd0, 1'b0, 64'h80,        64'h1080,      1'b0, 1'b1, 2'd2},
        '{2'd0, 1'b0, 3'd0, 1'b0, 64'h100,       64'h0,         1'b1, 1'b1, 2'd2},
        '{2'd0, 1'b0, 3'd0, 1'b0, 64'hFF,        64'h10FF,      1'b0, 1'b1, 2'd2},
        '{2'd1, 1'b0, 3'd0, 1'b0, 64'h7FFF,      64'h27FFF,     1'b0, 1'b0, 2'd0},
        '{2'd3, 1'b0, 3'd0, 1'b0, 64'h3F,        64'h33F,       1'b0, 1'b1, 2'd1},
        '{2'd2, 1'b1, 3'd4, 1'b0, 64'h8,         64'h70000008,  1'b0, 1'b0, 2'd2},
        '{2'd0, 1'b1, 3'd5, 1'b0, 64'h10,        64'hA0010,     1'b0, 1'b1, 2'd0},
        '{2'd2, 1'b1, 3'd6, 1'b0, 64'h23456,     64'h73456,     1'b0, 1'b0, 2'd1},
        '{2'd1, 1'b1, 3'd3, 1'b0, 64'h40,        64'h0,         1'b1, 1'b1, 2'd1},
        '{2'd2, 1'b0, 3'd0, 1'b1, 64'h123456789, 64'h123456789, 1'b0, 1'b0, 2'd1},
        '{2'd2, 1'b1, 3'd4, 1'b1, 64'h5,         64'h70000005,  1'b0, 1'b0, 2'd2},
        '{2'd0, 1'b1, 3'd2, 1'b1, 64'h10,        64'h10,        1'b0, 1'b0, 2'd1},
        '{2'd0, 1'b0, 3'd0, 1'b1, 64'hFFFFFFFF,  64'hFFFFFFFF,  1'b0, 1'b1, 2'd2},
        '{2'd2, 1'b1, 3'd0, 1'b0, 64'h23456,     64'h0,         1'b1, 1'b1, 2'd2}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [2:0] idx, input logic [1:0] fld,
                      input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sreg = s; wr_idx = idx; wr_field = fld; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic xlate(input logic [1:0] k, input logic oe, input logic [2:0] o,
                         input logic m, input logic [63:0] off);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_ovr_en = oe; req_ovr_seg = o;
        mode64 = m; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R8 rsp_addr after reset", rsp_addr, 64'd0);
        rst_n = 1'b1;
        // R8: empty table faults in legacy mode
        xlate(2'd2, 1'b0, 3'd0, 1'b0, 64'h0);
        chk("R8 fault with zero limit", 64'(rsp_fault), 64'd1);
        chk("R7 valid one cycle later", 64'(rsp_valid), 64'd1);
        @(negedge clk);
        chk("R7 valid drops when idle", 64'(rsp_valid), 64'd0);

        // R9: program descriptors (base, limit, attr {priv,size}) and registers
        wr(1'b0, 3'd1, 2'd0, 64'h50000);    wr(1'b0, 3'd1, 2'd1, 64'h6F000);
        wr(1'b0, 3'd1, 2'd2, 64'h1);
        wr(1'b0, 3'd2, 2'd0, 64'h1000);     wr(1'b0, 3'd2, 2'd1, 64'h100);
        wr(1'b0, 3'd2, 2'd2, 64'h6);
        wr(1'b0, 3'd3, 2'd0, 64'h20000);    wr(1'b0, 3'd3, 2'd1, 64'h8000);
        wr(1'b0, 3'd3, 2'd2, 64'h0);
        wr(1'b0, 3'd4, 2'd0, 64'h300);      wr(1'b0, 3'd4, 2'd1, 64'h40);
        wr(1'b0, 3'd4, 2'd2, 64'h5);
        wr(1'b0, 3'd5, 2'd0, 64'h70000000); wr(1'b0, 3'd5, 2'd1, 64'h10);
        wr(1'b0, 3'd5, 2'd2, 64'h2);
        wr(1'b0, 3'd6, 2'd0, 64'hA0000);    wr(1'b0, 3'd6, 2'd1, 64'h1000);
        wr(1'b0, 3'd6, 2'd2, 64'h4);
        wr(1'b0, 3'd1, 2'd3, 64'hDEAD);     // field 3: no effect (R9)
        wr(1'b1, 3'd0, 2'd0, 64'd2);  wr(1'b1, 3'd1, 2'd0, 64'd3);
        wr(1'b1, 3'd2, 2'd0, 64'd1);  wr(1'b1, 3'd3, 2'd0, 64'd4);
        wr(1'b1, 3'd4, 2'd0, 64'd5);  wr(1'b1, 3'd5, 2'd0, 64'd6);
        wr(1'b1, 3'd6, 2'd0, 64'd7);        // index 6 ignored (R9)

        // Vector walk: R1..R6
        for (int i = 0; i < NV; i++) begin
            xlate(VECS[i].kind, VECS[i].ovr_en, VECS[i].ovr, VECS[i].m64, VECS[i].off);
            chk($sformatf("R1/R3/R4/R5 addr vec %0d", i), rsp_addr, VECS[i].addr);
            chk($sformatf("R2/R5 fault vec %0d", i), 64'(rsp_fault), 64'(VECS[i].fault));
            chk($sformatf("R6 priv vec %0d", i), 64'(rsp_priv), 64'(VECS[i].priv));
            chk($sformatf("R6 size vec %0d", i), 64'(rsp_size), 64'(VECS[i].size));
        end

        // R9: remap DS to descriptor 2, data access now uses that descriptor
        wr(1'b1, 3'd2, 2'd0, 64'd2);
        xlate(2'd2, 1'b0, 3'd0, 1'b0, 64'h80);
        chk("R9 DS remap addr", rsp_addr, 64'h1080);
        // R9: descriptor 1 limit unchanged by field-3 write (via override DS->desc1? use SS remap)
        wr(1'b1, 3'd1, 2'd0, 64'd1);
        xlate(2'd1, 1'b0, 3'd0, 1'b0, 64'h6EFFF);
        chk("R9 field 3 ignored", rsp_addr, 64'hBEFFF);
        chk("R2 one below limit", 64'(rsp_fault), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule